// File: doc/BRIEF.md
# Reference Switchover Mode Controller

This block sequences the operating mode of a clock synchronizer that can follow either of two timing references. A select pin picks which reference should be followed. A change on that pin does not swap the reference immediately. The controller first parks the loop in a short holdover with phase-step correction switched off. It waits a fixed dwell, then moves to the newly chosen reference and returns to normal tracking. Phase-step correction is restored from a pin at that moment.

Separately, an invalid-reference flag (loss of signal or out of capture range) sends the loop into automatic holdover until the flag clears. A two-bit mode input can force free-running or manual holdover, and this overrides the automatic sequence. On every entry into holdover from normal tracking, the loop receives a one-cycle freeze strobe so that it latches the frequency it has been holding. The loop itself is outside this block: its filter, its oscillator, its phase measurement and its frequency averaging.

Top module: `refsw_mode_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs are: freerun status 1, normal status 0, holdover status 0, hold request 0, freeze strobe 0, active reference 0, correction enable 0.
- R2: From freerun with mode input 2'b00 and invalid flag low, the controller enters normal on the next clock. The active reference is loaded with the synchronized select level (0 selects reference 0, 1 selects reference 1).
- R3: In normal, with mode 2'b00 and invalid low, a transition on the select pin puts the controller into short holdover on the third rising clock edge after the change (two synchronizer stages plus the state register). At that point holdover status and hold request are 1, correction enable is 0 and the active reference is unchanged.
- R4: Short holdover lasts DWELL_CYC clocks after the most recent select transition, and a further transition restarts the dwell. When the dwell ends, the controller returns to normal, the active reference takes the synchronized select level and correction enable takes the level of the correction pin. The active reference changes only on entry to normal.
- R5: In normal, a high invalid flag moves the controller to automatic holdover on the next clock, and this wins over a select transition in the same cycle. When the flag goes low the controller returns to normal with the active reference set to the current synchronized select level. Correction enable is left unchanged.
- R6: The invalid flag has no effect during short holdover. The switch still completes after the dwell.
- R7: Mode 2'b10 or 2'b11 forces freerun and mode 2'b01 forces manual holdover, each on the next clock from any state. On return to 2'b00, manual holdover goes to automatic holdover if the invalid flag is high, and to normal otherwise.
- R8: The freeze strobe is high for exactly one cycle, namely the first cycle of any holdover state entered directly from normal. It stays low on every other transition.
- R9: Exactly one of the normal, holdover and freerun status outputs is high at any time, and the hold request equals the holdover status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Asynchronous reference select, 0 = reference 0, 1 = reference 1 |
| ref_invalid | input | 1 | High when the followed reference is lost or out of capture range |
| tie_pin | input | 1 | Phase-step correction enable level applied after a switch |
| mode_sel | input | 2 | 00 automatic, 01 manual holdover, 1x freerun |
| active_ref | output | 1 | Index of the reference the loop follows |
| tie_auto_en | output | 1 | Phase-step correction enable to the loop |
| hold_req | output | 1 | Request to the loop to hold its frequency |
| freeze_stb | output | 1 | One-cycle strobe to latch the held frequency |
| st_normal | output | 1 | Normal tracking status |
| st_holdover | output | 1 | Holdover status (any kind) |
| st_freerun | output | 1 | Freerun status |

## Verification
The collision that matters is a select transition reaching the state register in the same cycle that the invalid flag rises during normal tracking. The bench provokes it by raising the flag exactly two clocks after a select change, so that both arrive at the same edge. It judges the outcome by correction enable staying high: automatic holdover keeps correction enable, while short holdover would have cleared it. A second overlap is a select transition on the very clock at which the dwell would expire. The random phase produces it and the cycle model checks it, and the restart must win.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic [2:0] {
    MD_FREERUN    = 3'd0,
    MD_NORMAL     = 3'd1,
    MD_SHORT_HOLD = 3'd2,
    MD_AUTO_HOLD  = 3'd3,
    MD_MAN_HOLD   = 3'd4
  } sw_mode_e;

  localparam logic [1:0] MSEL_AUTO = 2'b00;
  localparam logic [1:0] MSEL_HOLD = 2'b01;

  function automatic logic is_hold(input sw_mode_e m);
    return (m == MD_SHORT_HOLD) || (m == MD_AUTO_HOLD) || (m == MD_MAN_HOLD);
  endfunction

endpackage

// File: rtl/refsw_sel_sync.sv
module refsw_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_pin,
  output logic sel_level,
  output logic sel_toggle
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= sel_pin;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[gi] <= 1'b0;
        else     chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign sel_level  = chain[STAGES-1];
  assign sel_toggle = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/refsw_dwell_timer.sv
module refsw_dwell_timer #(
  parameter int DWELL_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic keep,
  output logic done
);
  localparam int CW = (DWELL_CYC > 2) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DWELL_CYC - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= LOAD;
      run <= 1'b1;
    end else if (run && keep && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      run <= 1'b0;
    end
  end

  assign done = run && (cnt == '0);

  // R4
  dwell_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);
  // R4
  dwell_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (run && cnt == LOAD));
endmodule

// File: rtl/refsw_mode_fsm.sv
module refsw_mode_fsm
  import refsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_level,
  input  logic       sel_toggle,
  input  logic       ref_invalid,
  input  logic       tie_pin,
  input  logic [1:0] mode_sel,
  input  logic       dwell_done,
  output logic       dwell_start,
  output logic       dwell_keep,
  output logic       active_ref,
  output logic       tie_auto_en,
  output logic       hold_req,
  output logic       freeze_stb,
  output logic       st_normal,
  output logic       st_holdover,
  output logic       st_freerun
);
  sw_mode_e state, nxt;
  logic     ref_n, tie_n;

  always_comb begin
    nxt         = state;
    ref_n       = active_ref;
    tie_n       = tie_auto_en;
    dwell_start = 1'b0;
    if (mode_sel[1]) begin
      nxt = MD_FREERUN;
    end else if (mode_sel == MSEL_HOLD) begin
      nxt = MD_MAN_HOLD;
    end else begin
      unique case (state)
        MD_FREERUN: if (!ref_invalid) begin
          nxt   = MD_NORMAL;
          ref_n = sel_level;
        end
        MD_NORMAL: begin
          if (ref_invalid) begin
            nxt = MD_AUTO_HOLD;
          end else if (sel_toggle) begin
            nxt         = MD_SHORT_HOLD;
            tie_n       = 1'b0;
            dwell_start = 1'b1;
          end
        end
        MD_SHORT_HOLD: begin
          if (sel_toggle) begin
            dwell_start = 1'b1;
          end else if (dwell_done) begin
            nxt   = MD_NORMAL;
            ref_n = sel_level;
            tie_n = tie_pin;
          end
        end
        MD_AUTO_HOLD: if (!ref_invalid) begin
          nxt   = MD_NORMAL;
          ref_n = sel_level;
        end
        MD_MAN_HOLD: begin
          if (ref_invalid) begin
            nxt = MD_AUTO_HOLD;
          end else begin
            nxt   = MD_NORMAL;
            ref_n = sel_level;
          end
        end
        default: nxt = MD_FREERUN;
      endcase
    end
  end

  assign dwell_keep = (nxt == MD_SHORT_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= MD_FREERUN;
      active_ref  <= 1'b0;
      tie_auto_en <= 1'b0;
      hold_req    <= 1'b0;
      freeze_stb  <= 1'b0;
      st_normal   <= 1'b0;
      st_holdover <= 1'b0;
      st_freerun  <= 1'b1;
    end else begin
      state       <= nxt;
      active_ref  <= ref_n;
      tie_auto_en <= tie_n;
      hold_req    <= is_hold(nxt);
      freeze_stb  <= (state == MD_NORMAL) && is_hold(nxt);
      st_normal   <= (nxt == MD_NORMAL);
      st_holdover <= is_hold(nxt);
      st_freerun  <= (nxt == MD_FREERUN);
    end
  end

  // R9
  one_status_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({st_normal, st_holdover, st_freerun}) == 1);
  // R9
  hold_match_chk: assert property (@(posedge clk) disable iff (rst)
    hold_req == st_holdover);
  // R8
  freeze_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    freeze_stb |=> !freeze_stb);
  // R8
  freeze_entry_chk: assert property (@(posedge clk) disable iff (rst)
    freeze_stb |-> (st_holdover && $past(st_normal)));
  // R7
  force_freerun_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sel[1] |=> st_freerun);
  // R3
  s4_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st_normal && sel_toggle && !ref_invalid && mode_sel == MSEL_AUTO)
      |=> (st_holdover && !tie_auto_en && $stable(active_ref)));
  // R4
  ref_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_ref) |-> st_normal);
endmodule

// File: rtl/refsw_mode_ctrl.sv
module refsw_mode_ctrl #(
  parameter int DWELL_CYC   = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_pin,
  input  logic       ref_invalid,
  input  logic       tie_pin,
  input  logic [1:0] mode_sel,
  output logic       active_ref,
  output logic       tie_auto_en,
  output logic       hold_req,
  output logic       freeze_stb,
  output logic       st_normal,
  output logic       st_holdover,
  output logic       st_freerun
);
  logic sel_level, sel_toggle;
  logic dwell_start, dwell_keep, dwell_done;

  refsw_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sel_pin(sel_pin),
    .sel_level(sel_level), .sel_toggle(sel_toggle)
  );

  refsw_dwell_timer #(.DWELL_CYC(DWELL_CYC)) u_dwell (
    .clk(clk), .rst(rst), .start(dwell_start), .keep(dwell_keep),
    .done(dwell_done)
  );

  refsw_mode_fsm u_fsm (
    .clk(clk), .rst(rst),
    .sel_level(sel_level), .sel_toggle(sel_toggle),
    .ref_invalid(ref_invalid), .tie_pin(tie_pin), .mode_sel(mode_sel),
    .dwell_done(dwell_done), .dwell_start(dwell_start), .dwell_keep(dwell_keep),
    .active_ref(active_ref), .tie_auto_en(tie_auto_en), .hold_req(hold_req),
    .freeze_stb(freeze_stb), .st_normal(st_normal), .st_holdover(st_holdover),
    .st_freerun(st_freerun)
  );
endmodule

// File: tb/tb_refsw_mode_ctrl.sv
module tb_refsw_mode_ctrl;
  localparam int D = 12;
  localparam int ST_FR = 0, ST_N = 1, ST_S4 = 2, ST_AH = 3, ST_MH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_pin = 1'b0, ref_invalid = 1'b0, tie_pin = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic active_ref, tie_auto_en, hold_req, freeze_stb;
  logic st_normal, st_holdover, st_freerun;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  refsw_mode_ctrl #(.DWELL_CYC(D), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .sel_pin(sel_pin), .ref_invalid(ref_invalid),
    .tie_pin(tie_pin), .mode_sel(mode_sel), .active_ref(active_ref),
    .tie_auto_en(tie_auto_en), .hold_req(hold_req), .freeze_stb(freeze_stb),
    .st_normal(st_normal), .st_holdover(st_holdover), .st_freerun(st_freerun)
  );

  // cycle model built from the requirements
  int m_st = ST_FR, m_cnt = 0;
  bit m_ref = 0, m_tie = 0, m_frz = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;

  function automatic bit hold_of(int s);
    return (s == ST_S4) || (s == ST_AH) || (s == ST_MH);
  endfunction

  always @(posedge clk) begin
    bit e, lvl, was_n;
    if (rst) begin
      m_st = ST_FR; m_ref = 0; m_tie = 0; m_frz = 0; m_cnt = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      e = m_s2 ^ m_s3; lvl = m_s2; was_n = (m_st == ST_N);
      if (mode_sel[1]) m_st = ST_FR;
      else if (mode_sel == 2'b01) m_st = ST_MH;
      else begin
        case (m_st)
          ST_FR: if (!ref_invalid) begin m_st = ST_N; m_ref = lvl; end
          ST_N: begin
            if (ref_invalid) m_st = ST_AH;
            else if (e) begin m_st = ST_S4; m_tie = 0; m_cnt = D; end
          end
          ST_S4: begin
            if (e) m_cnt = D;
            else if (m_cnt == 1) begin m_st = ST_N; m_ref = lvl; m_tie = tie_pin; end
            else m_cnt = m_cnt - 1;
          end
          ST_AH: if (!ref_invalid) begin m_st = ST_N; m_ref = lvl; end
          default: begin
            if (ref_invalid) m_st = ST_AH;
            else begin m_st = ST_N; m_ref = lvl; end
          end
        endcase
      end
      m_frz = was_n && hold_of(m_st);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sel_pin;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  bit mon_on = 0;
  always @(negedge clk) begin
    if (mon_on && !rst && !done_flag) begin
      chk("R4 model active_ref", active_ref, m_ref);
      chk("R4 model tie_auto_en", tie_auto_en, m_tie);
      chk("R9 model hold_req", hold_req, hold_of(m_st));
      chk("R2 model st_normal", st_normal, m_st == ST_N);
      chk("R3 model st_holdover", st_holdover, hold_of(m_st));
      chk("R7 model st_freerun", st_freerun, m_st == ST_FR);
      chk("R8 model freeze_stb", freeze_stb, m_frz);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    // R1 reset values
    chk("R1 st_freerun", st_freerun, 1);
    chk("R1 hold_req", hold_req, 0);
    chk("R1 active_ref", active_ref, 0);
    chk("R1 tie_auto_en", tie_auto_en, 0);
    chk("R1 freeze_stb", freeze_stb, 0);
    rst = 0;
    mon_on = 1;
    tick(1);
    chk("R2 enter normal", st_normal, 1);
    // R3 latency and entry
    tie_pin = 1; sel_pin = 1;
    tick(2);
    chk("R3 still normal before sync", st_normal, 1);
    tick(1);
    chk("R3 short hold", st_holdover, 1);
    chk("R3 tie cleared", tie_auto_en, 0);
    chk("R3 ref unchanged", active_ref, 0);
    chk("R8 freeze on entry", freeze_stb, 1);
    tick(1);
    chk("R8 freeze single", freeze_stb, 0);
    tick(D - 2);
    chk("R4 hold until dwell", st_holdover, 1);
    tick(1);
    chk("R4 back normal", st_normal, 1);
    chk("R4 ref switched", active_ref, 1);
    chk("R4 tie from pin", tie_auto_en, 1);
    // R4 restart
    sel_pin = 0; tick(3); tick(4);
    sel_pin = 1; tick(3); tick(D - 1);
    chk("R4 restart keeps hold", st_holdover, 1);
    tick(1);
    chk("R4 restart exit", st_normal, 1);
    chk("R4 restart ref", active_ref, 1);
    // R5 invalid
    ref_invalid = 1; tick(1);
    chk("R5 auto hold", st_holdover, 1);
    ref_invalid = 0; tick(1);
    chk("R5 auto return", st_normal, 1);
    // R5 collision with select edge
    sel_pin = 0; tick(2);
    ref_invalid = 1; tick(1);
    chk("R5 invalid wins hold", st_holdover, 1);
    chk("R5 invalid wins tie kept", tie_auto_en, 1);
    ref_invalid = 0; tick(1);
    chk("R5 return ref level", active_ref, 0);
    // R6 invalid ignored in short hold
    sel_pin = 1; tick(3);
    ref_invalid = 1; tick(D - 1);
    chk("R6 still short hold", st_holdover, 1);
    tick(1);
    chk("R6 switch done", st_normal, 1);
    chk("R6 ref", active_ref, 1);
    tick(1);
    chk("R6 then auto hold", st_holdover, 1);
    ref_invalid = 0; tick(1);
    // R7 mode overrides
    mode_sel = 2'b10; tick(1);
    chk("R7 forced freerun", st_freerun, 1);
    mode_sel = 2'b01; tick(1);
    chk("R7 manual hold", st_holdover, 1);
    chk("R8 no freeze from freerun", freeze_stb, 0);
    mode_sel = 2'b00; tick(1);
    chk("R7 manual exit normal", st_normal, 1);
    mode_sel = 2'b01; tick(1);
    chk("R8 freeze manual from normal", freeze_stb, 1);
    mode_sel = 2'b00; ref_invalid = 1; tick(1);
    chk("R7 manual exit to auto hold", st_holdover, 1);
    ref_invalid = 0; tick(1);
    chk("R9 single status", st_normal + st_holdover + st_freerun, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) sel_pin = ~sel_pin;
      if ($urandom_range(0, 39) == 0) ref_invalid = ~ref_invalid;
      if (mode_sel == 2'b00) begin
        if ($urandom_range(0, 79) == 0) mode_sel = 2'($urandom_range(1, 3));
      end else if ($urandom_range(0, 5) == 0) mode_sel = 2'b00;
      tie_pin = 1'($urandom_range(0, 1));
      tick(1);
    end
    finish_run();
  end
endmodule